// File: doc/BRIEF.md
# Circular Buffer Mailbox with Read Window

This block is a ring of 32-bit entries shared by two parties. An embedded controller fills the ring through a simple write port. A host drains it through one read-window location. A host read of that window returns the entry at the read position and moves the read position on by one slot. The read only counts when the ready input is high and the ring holds data. In every other case the window returns all ones and nothing changes.

A 32-bit status word tells software the ring size, the read position and the write position. The ring size is given as a one-hot power of two. From these fields software works out the number of entries waiting as (write − read) mod depth, and the free space from that. One slot is always kept empty, so a full ring holds depth − 1 entries. When the embedded side writes into a full ring, the write is dropped and a one-cycle overflow pulse is raised.

Top module: `cbmb_mailbox`

## Requirements
- R1: Entries are 32 bits wide. Words written on the embedded port come back through the read window unchanged and in the order they were written.
- R2: status_o[31:24] holds a one-hot depth code: bit DEPTH_LOG2 is set and the depth is 2^DEPTH_LOG2. DEPTH_LOG2 must be in the range 1 to 7. status_o[7:0] reads zero.
- R3: status_o[23:16] holds the write position, zero-extended. It steps by one on every accepted embedded write.
- R4: status_o[15:8] holds the read position, zero-extended. It steps by one on every valid window read, which means win_rd_i high, rdy_i high and the ring not empty.
- R5: While rdy_i is low, a window read returns 32'hFFFFFFFF and leaves the read position unchanged.
- R6: A host write strobe to the window (win_wr_i) has no effect. Both positions and the stored data stay unchanged.
- R7: Both positions wrap to 0 after slot depth − 1.
- R8: A window read with the ring empty returns 32'hFFFFFFFF and does not move the read position.
- R9: The ring is full at depth − 1 entries. An embedded write into a full ring is dropped, so the write position does not move. ovf_o is then high for exactly the following cycle.
- R10: While rst_n is low, both positions return to 0 and ovf_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rdy_i | input | 1 | Ready flag that gates window reads |
| prod_wr_i | input | 1 | Embedded-side write strobe |
| prod_data_i | input | 32 | Embedded-side write data |
| win_rd_i | input | 1 | Host read strobe for the window |
| win_wr_i | input | 1 | Host write strobe for the window (ignored) |
| win_rdata_o | output | 32 | Window read data (all ones when the read is not valid) |
| status_o | output | 32 | Depth code, write position and read position |
| ovf_o | output | 1 | Dropped-write pulse |

## Verification
The ring is first filled with a short burst and drained. This separates correct ordering and pointer stepping from stuck or swapped positions. Reads are then issued with the ready flag low, and reads are issued on an empty ring. Both must return all ones with the read position frozen, which tells a gated read apart from one that is silently consumed. A fill to capacity plus one extra write exposes any off-by-one in the full test and the timing of the overflow pulse. A final run of writes and reads carries both positions past the top slot to show the wrap.

// File: rtl/cbmb_pkg.sv
package cbmb_pkg;
   localparam int unsigned ENTRY_W = 32;
   typedef logic [ENTRY_W-1:0] entry_t;
   localparam entry_t ENTRY_ONES = '1;

   function automatic logic [7:0] depth_code(input int unsigned log2_depth);
      return 8'(1 << log2_depth);
   endfunction
endpackage

// File: rtl/cbmb_ptr.sv
module cbmb_ptr #(
   parameter int unsigned AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_i,
   output logic [AW-1:0] ptr_o
);
   localparam logic [AW-1:0] LAST = '1;

   logic [AW-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr_q <= '0;
      else if (adv_i) ptr_q <= ptr_q + 1'b1;
   end

   assign ptr_o = ptr_q;

   // R7: the top slot is followed by slot zero
   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && ptr_q == LAST) |=> (ptr_q == '0));

   // R10: held at zero while reset is applied
   always_comb begin
      if (!rst_n) a_rst_zero_r10: assert (ptr_q == '0);
   end
endmodule

// File: rtl/cbmb_store.sv
module cbmb_store
   import cbmb_pkg::*;
#(
   parameter int unsigned AW          = 3,
   parameter bit          RESET_SLOTS = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  entry_t        wdata_i,
   input  logic [AW-1:0] raddr_i,
   output entry_t        rdata_o
);
   localparam int unsigned DEPTH = 1 << AW;

   entry_t slot_q [DEPTH];

   generate
      if (RESET_SLOTS) begin : g_rst_slots
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
            end else if (we_i) begin
               slot_q[waddr_i] <= wdata_i;
            end
         end
      end else begin : g_plain_slots
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (we_i) slot_q[waddr_i] <= wdata_i;
         end
      end
   endgenerate

   assign rdata_o = slot_q[raddr_i];
endmodule

// File: rtl/cbmb_status.sv
module cbmb_status #(
   parameter int unsigned DEPTH_LOG2 = 3
) (
   input  logic [DEPTH_LOG2-1:0] wptr_i,
   input  logic [DEPTH_LOG2-1:0] rptr_i,
   output logic [31:0]           word_o
);
   localparam int unsigned PAD = 8 - DEPTH_LOG2;
   localparam logic [7:0] DCODE = cbmb_pkg::depth_code(DEPTH_LOG2);

   logic [7:0] wfield, rfield;

   generate
      if (PAD > 0) begin : g_pad
         assign wfield = {{PAD{1'b0}}, wptr_i};
         assign rfield = {{PAD{1'b0}}, rptr_i};
      end else begin : g_full
         assign wfield = 8'(wptr_i);
         assign rfield = 8'(rptr_i);
      end
   endgenerate

   assign word_o = {DCODE, wfield, rfield, 8'h00};
endmodule

// File: rtl/cbmb_mailbox.sv
module cbmb_mailbox
   import cbmb_pkg::*;
#(
   parameter int unsigned DEPTH_LOG2  = 3,
   parameter bit          RESET_SLOTS = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rdy_i,
   input  logic        prod_wr_i,
   input  logic [31:0] prod_data_i,
   input  logic        win_rd_i,
   input  logic        win_wr_i,
   output logic [31:0] win_rdata_o,
   output logic [31:0] status_o,
   output logic        ovf_o
);
   localparam int unsigned AW = DEPTH_LOG2;
   localparam logic [AW-1:0] CAP = '1;

   generate
      if (DEPTH_LOG2 < 1 || DEPTH_LOG2 > 7) begin : g_bad_depth
         $error("cbmb_mailbox: DEPTH_LOG2 must lie in 1..7");
      end
   endgenerate

   logic [AW-1:0] wptr, rptr, fill;
   logic          empty, full, wr_ok, rd_ok, ovf_q;
   entry_t        slot_data;

   assign fill  = wptr - rptr;
   assign empty = (fill == '0);
   assign full  = (fill == CAP);
   assign wr_ok = prod_wr_i && !full;
   assign rd_ok = win_rd_i && rdy_i && !empty;

   cbmb_ptr #(.AW(AW)) u_wptr (
      .clk(clk), .rst_n(rst_n), .adv_i(wr_ok), .ptr_o(wptr));

   cbmb_ptr #(.AW(AW)) u_rptr (
      .clk(clk), .rst_n(rst_n), .adv_i(rd_ok), .ptr_o(rptr));

   cbmb_store #(.AW(AW), .RESET_SLOTS(RESET_SLOTS)) u_store (
      .clk(clk), .rst_n(rst_n), .we_i(wr_ok), .waddr_i(wptr),
      .wdata_i(prod_data_i), .raddr_i(rptr), .rdata_o(slot_data));

   cbmb_status #(.DEPTH_LOG2(DEPTH_LOG2)) u_status (
      .wptr_i(wptr), .rptr_i(rptr), .word_o(status_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_q <= 1'b0;
      else        ovf_q <= prod_wr_i && full;
   end

   assign ovf_o       = ovf_q;
   assign win_rdata_o = rd_ok ? slot_data : ENTRY_ONES;

   // R3: accepted write moves the write position by one
   p_wptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (prod_wr_i && !full) |=> (wptr == $past(wptr) + 1'b1));

   // R4: valid read moves the read position by one
   p_rptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (win_rd_i && rdy_i && !empty) |=> (rptr == $past(rptr) + 1'b1));

   // R5: gated read gives all ones and freezes the read position
   p_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_rd_i && !rdy_i) |-> (win_rdata_o == ENTRY_ONES));
   p_not_ready_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_rd_i || !rdy_i) |=> $stable(rptr));

   // R6: window write strobe leaves positions alone
   p_win_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr_i && !win_rd_i && !prod_wr_i) |=> ($stable(rptr) && $stable(wptr)));

   // R8: empty read gives all ones
   p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (win_rd_i && empty) |-> (win_rdata_o == ENTRY_ONES));

   // R9: write into a full ring is dropped and flagged
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (prod_wr_i && full) |=> (ovf_o && $stable(wptr)));
   p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(prod_wr_i && full) |=> !ovf_o);
endmodule

// File: tb/cbmb_mailbox_bench.sv
module cbmb_mailbox_bench;
   localparam int LG    = 3;
   localparam int DEPTH = 1 << LG;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rdy_i = 1'b0;
   logic        prod_wr_i = 1'b0;
   logic [31:0] prod_data_i = '0;
   logic        win_rd_i = 1'b0;
   logic        win_wr_i = 1'b0;
   logic [31:0] win_rdata_o, status_o;
   logic        ovf_o;

   always #10 clk = ~clk;

   cbmb_mailbox u_cbmb_mailbox (
      .clk(clk), .rst_n(rst_n), .rdy_i(rdy_i), .prod_wr_i(prod_wr_i),
      .prod_data_i(prod_data_i), .win_rd_i(win_rd_i), .win_wr_i(win_wr_i),
      .win_rdata_o(win_rdata_o), .status_o(status_o), .ovf_o(ovf_o));

   int n_cmp = 0;
   int n_bad = 0;
   int m_w = 0;
   int m_r = 0;
   logic [31:0] sb_q[$];
   bit done = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_status();
      return {8'(1 << LG), 8'(m_w), 8'(m_r), 8'h00};
   endfunction

   task automatic push_word(input logic [31:0] d);
      @(negedge clk);
      prod_wr_i = 1'b1; prod_data_i = d;
      @(negedge clk);
      prod_wr_i = 1'b0;
      if (sb_q.size() < DEPTH - 1) begin
         sb_q.push_back(d);
         m_w = (m_w + 1) % DEPTH;
      end
   endtask

   task automatic pop_check(input string req, input bit rdy);
      logic [31:0] exp;
      bool_valid: begin end
      @(negedge clk);
      win_rd_i = 1'b1; rdy_i = rdy;
      #1;
      if (rdy && sb_q.size() > 0) begin
         exp = sb_q.pop_front();
         m_r = (m_r + 1) % DEPTH;
      end else begin
         exp = 32'hFFFF_FFFF;
      end
      check(req, win_rdata_o, exp);
      @(negedge clk);
      win_rd_i = 1'b0; rdy_i = 1'b0;
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state, R2 depth code
      check("R10", status_o, exp_status());
      check("R10", {31'd0, ovf_o}, 32'd0);
      check("R2", {24'd0, status_o[31:24]}, 32'h08);
      rst_n = 1'b1;

      // R3, R1, R4: short burst then drain
      push_word(32'hA5A5_0001);
      push_word(32'h1234_5678);
      push_word(32'hDEAD_BEEF);
      @(negedge clk);
      check("R3", status_o, exp_status());
      for (int i = 0; i < 3; i++) pop_check("R1", 1'b1);
      check("R4", status_o, exp_status());

      // R8: empty read
      pop_check("R8", 1'b1);
      check("R8", status_o, exp_status());

      // R5: ready low with data present
      push_word(32'h0F0F_F0F0);
      pop_check("R5", 1'b0);
      check("R5", status_o, exp_status());

      // R6: window write strobe is ignored
      @(negedge clk); win_wr_i = 1'b1;
      @(negedge clk); win_wr_i = 1'b0;
      check("R6", status_o, exp_status());
      pop_check("R6", 1'b1);

      // R9: fill to capacity, then one more
      for (int i = 0; i < DEPTH - 1; i++) push_word(32'hC000_0000 + i);
      check("R9", status_o, exp_status());
      @(negedge clk);
      prod_wr_i = 1'b1; prod_data_i = 32'hBAD0_BAD0;
      @(negedge clk);
      prod_wr_i = 1'b0;
      check("R9", {31'd0, ovf_o}, 32'd1);
      check("R9", status_o, exp_status());
      @(negedge clk);
      check("R9", {31'd0, ovf_o}, 32'd0);
      for (int i = 0; i < DEPTH - 1; i++) pop_check("R9", 1'b1);

      // R7: positions carry past the top slot
      for (int i = 0; i < 5; i++) begin
         push_word(32'h7000_0000 + i);
         pop_check("R7", 1'b1);
      end
      check("R7", status_o, exp_status());
      check("R7", {24'd0, status_o[23:16]}, 32'(m_w));

      done = 1;
      report();
   end
endmodule